// File: doc/BRIEF.md
# Single-Channel Buffer DMA Engine

This block copies a run of bytes between host memory and a small on-device byte buffer. Software fills three 64-bit registers (source address, destination address and byte count) and then writes a command word. The command word selects the copy direction, enables a completion interrupt and sets a go bit. The go bit reads back as 1 for as long as the copy runs, so software polls it until it reads 0. The buffer is reached inside the device's 20-bit register space at a window that starts at 0x40000. The address written for the device side of a copy is a window address. The engine subtracts the window base from it.

A copy is checked before it starts. The device-side range must lie fully inside the buffer. The host-side range must fit under a configurable host address width, 28 bits by default. If either test fails, the copy is refused: no host traffic is generated and an error bit is set instead. An accepted copy moves one byte for each request/acknowledge handshake on a byte-wide host master port. It raises a one-cycle done pulse, and optionally the interrupt cause value 0x100, in the cycle after the last byte.

Top module: `dma_copy_top`

## Requirements
- R1: The registers sit at 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command). An 8-byte access (`reg_wide`=1) reads or writes the whole 64-bit register. A 4-byte access moves `reg_wdata[31:0]` into the low half when address bit 2 is 0, or into the high half when it is 1. A 4-byte read returns the selected half in bits 31:0, with zeros above.
- R2: A command read returns bit 0 = busy, bit 1 = direction, bit 2 = interrupt enable and bit 3 = error, with all other bits 0.
- R3: Direction 0 copies host bytes into the buffer. Byte i is requested from host address src+i and is stored at buffer offset (dst-0x40000)+i, with host addresses issued in increasing order.
- R4: Direction 1 copies buffer offset (src-0x40000)+i out to host address dst+i. Host bytes outside that range are left unchanged.
- R5: `hst_req` stays high with stable `hst_addr`, `hst_we` and `hst_wdata` until `hst_ack`. Each acknowledged cycle moves exactly one byte, and the number of handshakes equals the count.
- R6: `done` pulses for one cycle. For a nonzero count it comes in the cycle after the last acknowledged byte, with busy already 0. A zero count completes in the cycle after the command write, with no host traffic.
- R7: During the `done` cycle, `irq_set` equals 0x100 if command bit 2 was 1 at the start, and 0 otherwise. `irq_set` is 0 in every other cycle.
- R8: A go request is refused when the device address is below 0x40000, when (device offset + count) exceeds the buffer size, or when (host address + count) exceeds 2^DMA_BITS. A refused request makes no host request and no done, and it sets error (bit 3) with busy 0. An accepted start clears error.
- R9: While busy, writes to the source, destination, count and command registers and to the buffer window are ignored. This includes a write in the same cycle as the last handshake.
- R10: A write at 0x40000+k (k below the buffer size) stores `reg_wdata[7:0]` at buffer offset k. A read there returns that byte zero-extended. Every read returns its data one clock after `reg_re`.
- R11: After reset, all four registers read 0, and `hst_req`, `done` and `irq_set` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register/window write strobe |
| reg_re | input | 1 | Register/window read strobe |
| reg_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_addr | input | 20 | Byte address in device space |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid one cycle after `reg_re` |
| hst_req | output | 1 | Host byte request |
| hst_we | output | 1 | 1 = host write, 0 = host read |
| hst_addr | output | DMA_BITS | Host byte address |
| hst_wdata | output | 8 | Byte to write to host |
| hst_ack | input | 1 | Host completes the current byte |
| hst_rdata | input | 8 | Host read byte, valid with `hst_ack` |
| done | output | 1 | One-cycle completion pulse |
| irq_set | output | 32 | Interrupt cause bits raised at completion |

## Verification
The interesting overlap is a software register write landing in the same cycle as the final byte handshake. Busy is still 1 in that cycle, so the write must be discarded even though the engine goes idle at that edge. The bench provokes this by driving a count write on the same falling edge where it raises the acknowledge for the last byte. It then reads the count back unchanged, confirms that done arrived exactly one cycle later, and shows that a write issued after done does take effect. Window writes are likewise injected mid-copy, in cycles where the engine itself writes the buffer, and the full buffer is read back afterwards.

// File: rtl/dma_copy_pkg.sv
// Shared constants and types for the buffer DMA engine.
// Assumes a 20-bit device address space with the buffer window at 0x40000.
package dma_copy_pkg;

    localparam logic [19:0] WIN_BASE  = 20'h40000;
    localparam logic [14:0] REG_PAGE  = 15'h004;   // 0x80..0x9F
    localparam logic [31:0] IRQ_CAUSE = 32'h0000_0100;

    typedef enum logic [1:0] {
        RI_SRC = 2'd0,
        RI_DST = 2'd1,
        RI_CNT = 2'd2,
        RI_CMD = 2'd3
    } reg_idx_e;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IRQ = 2;
    localparam int CMD_ERR = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MOVE = 1'b1
    } eng_st_e;

    // Merge a 4- or 8-byte write into a 64-bit register.
    function automatic logic [63:0] lane_merge(input logic [63:0] old_v,
                                               input logic [63:0] new_v,
                                               input logic        wide,
                                               input logic        hi);
        if (wide)
            return new_v;
        else if (hi)
            return {new_v[31:0], old_v[31:0]};
        else
            return {old_v[63:32], new_v[31:0]};
    endfunction

endpackage

// File: rtl/dma_copy_lbuf.sv
// Byte-wide local buffer with an engine port (a) and a software window port (b).
// Assumes the register file blocks port-b writes while the engine is busy;
// port a wins if both ever write.
module dma_copy_lbuf #(
    parameter int BUF_BYTES = 4096,
    parameter int BUF_AW    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [BUF_AW-1:0] a_addr,
    input  logic [7:0]        a_wdata,
    output logic [7:0]        a_rdata,
    input  logic              b_we,
    input  logic [BUF_AW-1:0] b_addr,
    input  logic [7:0]        b_wdata,
    output logic [7:0]        b_rdata
);

    logic [7:0] mem [BUF_BYTES];

    // Store one byte per cycle, engine first.
    always_ff @(posedge clk) begin
        if (a_we)
            mem[a_addr] <= a_wdata;
        else if (b_we)
            mem[b_addr] <= b_wdata;
    end

    assign a_rdata = mem[a_addr];
    assign b_rdata = mem[b_addr];

    // R9: the window never writes while the engine writes.
    p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_we && b_we));

endmodule

// File: rtl/dma_copy_regs.sv
// Register file: source, destination, count and command registers, buffer
// window decode, go-request validation and registered read data.
// Assumes busy comes from the engine and is high for the whole copy.
module dma_copy_regs
    import dma_copy_pkg::*;
#(
    parameter int BUF_BYTES = 4096,
    parameter int DMA_BITS  = 28,
    parameter int BUF_AW    = $clog2(BUF_BYTES),
    parameter int CNT_W     = BUF_AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic                reg_re,
    input  logic                reg_wide,
    input  logic [19:0]         reg_addr,
    input  logic [63:0]         reg_wdata,
    output logic [63:0]         reg_rdata,
    input  logic                busy,
    output logic                start,
    output logic                start_dir,
    output logic                start_irq,
    output logic [DMA_BITS-1:0] start_host,
    output logic [BUF_AW-1:0]   start_dev,
    output logic [CNT_W-1:0]    start_cnt,
    output logic                win_we,
    output logic [BUF_AW-1:0]   win_addr,
    output logic [7:0]          win_wdata,
    input  logic [7:0]          win_rdata
);

    logic [63:0] src_q, dst_q, cnt_q, rdata_q;
    logic        dir_q, irq_q, err_q;

    // Address decode.
    logic        in_regs, lane_hi, in_win, wr_ok, cmd_wr, go_req, reject;
    reg_idx_e    ridx;
    logic [19:0] win_off;

    assign in_regs = (reg_addr[19:5] == REG_PAGE);
    assign ridx    = reg_idx_e'(reg_addr[4:3]);
    assign lane_hi = reg_addr[2];
    assign win_off = reg_addr - WIN_BASE;
    assign in_win  = (reg_addr >= WIN_BASE) && (32'(win_off) < 32'(BUF_BYTES));
    assign wr_ok   = reg_we && !busy;
    assign cmd_wr  = wr_ok && in_regs && (ridx == RI_CMD) && (reg_wide || !lane_hi);
    assign go_req  = cmd_wr && reg_wdata[CMD_GO];

    // Range checks on the copy about to start.
    logic        new_dir;
    logic [63:0] dev_full, host_full;
    logic [64:0] dev_rel, host_end;
    logic        dev_ok, host_ok;

    assign new_dir   = reg_wdata[CMD_DIR];
    assign dev_full  = new_dir ? src_q : dst_q;
    assign host_full = new_dir ? dst_q : src_q;
    assign dev_rel   = {1'b0, dev_full} - 65'(WIN_BASE);
    assign host_end  = {1'b0, host_full} + {1'b0, cnt_q};
    assign dev_ok    = !dev_rel[64] && (cnt_q <= 64'(BUF_BYTES))
                       && (dev_rel[63:0] <= (64'(BUF_BYTES) - cnt_q));
    assign host_ok   = host_end <= (65'd1 << DMA_BITS);

    assign start      = go_req && dev_ok && host_ok;
    assign reject     = go_req && !(dev_ok && host_ok);
    assign start_dir  = new_dir;
    assign start_irq  = reg_wdata[CMD_IRQ];
    assign start_host = host_full[DMA_BITS-1:0];
    assign start_dev  = dev_rel[BUF_AW-1:0];
    assign start_cnt  = cnt_q[CNT_W-1:0];

    // Window port towards the buffer.
    assign win_we    = wr_ok && in_win;
    assign win_addr  = win_off[BUF_AW-1:0];
    assign win_wdata = reg_wdata[7:0];

    // Register writes, accepted only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            dir_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (wr_ok && in_regs) begin
            case (ridx)
                RI_SRC: src_q <= lane_merge(src_q, reg_wdata, reg_wide, lane_hi);
                RI_DST: dst_q <= lane_merge(dst_q, reg_wdata, reg_wide, lane_hi);
                RI_CNT: cnt_q <= lane_merge(cnt_q, reg_wdata, reg_wide, lane_hi);
                RI_CMD: if (reg_wide || !lane_hi) begin
                    dir_q <= reg_wdata[CMD_DIR];
                    irq_q <= reg_wdata[CMD_IRQ];
                end
                default: ;
            endcase
        end
    end

    // Error flag: set by a refused go, cleared by an accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (start)
            err_q <= 1'b0;
        else if (reject)
            err_q <= 1'b1;
    end

    // Read mux.
    logic [63:0] word, rd_sel;
    always_comb begin
        case (ridx)
            RI_SRC:  word = src_q;
            RI_DST:  word = dst_q;
            RI_CNT:  word = cnt_q;
            default: word = {60'b0, err_q, irq_q, dir_q, busy};
        endcase
        if (in_regs)
            rd_sel = reg_wide ? word
                              : {32'b0, (lane_hi ? word[63:32] : word[31:0])};
        else if (in_win)
            rd_sel = {56'b0, win_rdata};
        else
            rd_sel = '0;
    end

    // Read data register, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (reg_re)
            rdata_q <= rd_sel;
    end

    assign reg_rdata = rdata_q;

    // R9: programmed state holds across any cycle that starts busy.
    p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)
                  && $stable(dir_q) && $stable(irq_q)));

endmodule

// File: rtl/dma_copy_engine.sv
// Copy engine: after a validated start, moves one byte per host handshake,
// counts down the remaining bytes and pulses done in the following cycle.
// Assumes start arrives only while idle and its range is already checked.
module dma_copy_engine
    import dma_copy_pkg::*;
#(
    parameter int DMA_BITS = 28,
    parameter int BUF_AW   = 12,
    parameter int CNT_W    = BUF_AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_dir,
    input  logic                start_irq,
    input  logic [DMA_BITS-1:0] start_host,
    input  logic [BUF_AW-1:0]   start_dev,
    input  logic [CNT_W-1:0]    start_cnt,
    output logic                busy,
    output logic                done,
    output logic [31:0]         irq_set,
    output logic                hst_req,
    output logic                hst_we,
    output logic [DMA_BITS-1:0] hst_addr,
    output logic [7:0]          hst_wdata,
    input  logic                hst_ack,
    input  logic [7:0]          hst_rdata,
    output logic [BUF_AW-1:0]   buf_addr,
    input  logic [7:0]          buf_rdata,
    output logic                buf_we,
    output logic [7:0]          buf_wdata
);

    eng_st_e             st_q;
    logic [DMA_BITS-1:0] host_ptr;
    logic [BUF_AW-1:0]   dev_ptr;
    logic [CNT_W-1:0]    remain;
    logic                dir_q, irq_q, done_q;

    // Sequencer: load on start, advance on each acknowledged byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            host_ptr <= '0;
            dev_ptr  <= '0;
            remain   <= '0;
            dir_q    <= 1'b0;
            irq_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    dir_q    <= start_dir;
                    irq_q    <= start_irq;
                    host_ptr <= start_host;
                    dev_ptr  <= start_dev;
                    remain   <= start_cnt;
                    if (start_cnt == '0)
                        done_q <= 1'b1;
                    else
                        st_q <= ST_MOVE;
                end
                ST_MOVE: if (hst_ack) begin
                    host_ptr <= host_ptr + 1'b1;
                    dev_ptr  <= dev_ptr + 1'b1;
                    remain   <= remain - 1'b1;
                    if (remain == CNT_W'(1)) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st_q == ST_MOVE);
    assign done      = done_q;
    assign irq_set   = (done_q && irq_q) ? IRQ_CAUSE : 32'h0;
    assign hst_req   = busy;
    assign hst_we    = dir_q;
    assign hst_addr  = host_ptr;
    assign hst_wdata = buf_rdata;
    assign buf_addr  = dev_ptr;
    assign buf_we    = busy && !dir_q && hst_ack;
    assign buf_wdata = hst_rdata;

    // R5: a pending request holds still until acknowledged.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && !hst_ack) |=> (hst_req && $stable(hst_addr)
                                   && $stable(hst_we) && $stable(hst_wdata)));

    // R6: completion is reported only once the engine is idle.
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !hst_req));

    // R7: interrupt cause appears only with completion.
    p_irq_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set != 32'h0) |-> done);

endmodule

// File: rtl/dma_copy_top.sv
// Top of the buffer DMA engine: register file, copy engine and local buffer.
// Assumes a single software master on the register port and a byte-wide
// host port that answers each request with an acknowledge.
module dma_copy_top
    import dma_copy_pkg::*;
#(
    parameter int BUF_BYTES = 4096,
    parameter int DMA_BITS  = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic                reg_re,
    input  logic                reg_wide,
    input  logic [19:0]         reg_addr,
    input  logic [63:0]         reg_wdata,
    output logic [63:0]         reg_rdata,
    output logic                hst_req,
    output logic                hst_we,
    output logic [DMA_BITS-1:0] hst_addr,
    output logic [7:0]          hst_wdata,
    input  logic                hst_ack,
    input  logic [7:0]          hst_rdata,
    output logic                done,
    output logic [31:0]         irq_set
);

    localparam int BUF_AW = $clog2(BUF_BYTES);
    localparam int CNT_W  = BUF_AW + 1;

    logic                busy, start, start_dir, start_irq;
    logic [DMA_BITS-1:0] start_host;
    logic [BUF_AW-1:0]   start_dev, win_addr, eng_addr;
    logic [CNT_W-1:0]    start_cnt;
    logic                win_we, eng_we;
    logic [7:0]          win_wdata, win_rdata, eng_wdata, eng_rdata;

    dma_copy_regs #(
        .BUF_BYTES (BUF_BYTES),
        .DMA_BITS  (DMA_BITS),
        .BUF_AW    (BUF_AW),
        .CNT_W     (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_wide   (reg_wide),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .start      (start),
        .start_dir  (start_dir),
        .start_irq  (start_irq),
        .start_host (start_host),
        .start_dev  (start_dev),
        .start_cnt  (start_cnt),
        .win_we     (win_we),
        .win_addr   (win_addr),
        .win_wdata  (win_wdata),
        .win_rdata  (win_rdata)
    );

    dma_copy_engine #(
        .DMA_BITS (DMA_BITS),
        .BUF_AW   (BUF_AW),
        .CNT_W    (CNT_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_dir  (start_dir),
        .start_irq  (start_irq),
        .start_host (start_host),
        .start_dev  (start_dev),
        .start_cnt  (start_cnt),
        .busy       (busy),
        .done       (done),
        .irq_set    (irq_set),
        .hst_req    (hst_req),
        .hst_we     (hst_we),
        .hst_addr   (hst_addr),
        .hst_wdata  (hst_wdata),
        .hst_ack    (hst_ack),
        .hst_rdata  (hst_rdata),
        .buf_addr   (eng_addr),
        .buf_rdata  (eng_rdata),
        .buf_we     (eng_we),
        .buf_wdata  (eng_wdata)
    );

    dma_copy_lbuf #(
        .BUF_BYTES (BUF_BYTES),
        .BUF_AW    (BUF_AW)
    ) u_lbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (eng_we),
        .a_addr  (eng_addr),
        .a_wdata (eng_wdata),
        .a_rdata (eng_rdata),
        .b_we    (win_we),
        .b_addr  (win_addr),
        .b_wdata (win_wdata),
        .b_rdata (win_rdata)
    );

endmodule

// File: tb/dma_copy_top_tb.sv
// Bench: small configuration (64-byte buffer, 10-bit host space) with a
// behavioural host memory, swept over directions, lengths, offsets and waits.
module dma_copy_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NBUF  = 64;
    localparam int HBITS = 10;
    localparam int HSIZE = 1 << HBITS;
    localparam logic [63:0] WIN = 64'h40000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0, reg_re = 1'b0, reg_wide = 1'b0;
    logic [19:0]      reg_addr = '0;
    logic [63:0]      reg_wdata = '0;
    logic [63:0]      reg_rdata;
    logic             hst_req, hst_we;
    logic [HBITS-1:0] hst_addr;
    logic [7:0]       hst_wdata;
    logic             hst_ack = 1'b0;
    logic [7:0]       hst_rdata = '0;
    logic             done;
    logic [31:0]      irq_set;

    int n_chk = 0, n_fail = 0;
    int req_cyc = 0, done_cyc = 0, irq_stray = 0;
    logic [7:0] hmem  [HSIZE];
    logic [7:0] hexp  [HSIZE];
    logic [7:0] bmodel[NBUF];

    dma_copy_top #(.BUF_BYTES(NBUF), .DMA_BITS(HBITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hst_req(hst_req), .hst_we(hst_we),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_ack(hst_ack),
        .hst_rdata(hst_rdata), .done(done), .irq_set(irq_set)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (hst_req) req_cyc++;
            if (done) done_cyc++;
            if (irq_set != 0 && !done) irq_stray++;
        end
    end

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [19:0] a, input logic [63:0] d, input logic w);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = w;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [19:0] a, input logic w, output logic [63:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a; reg_wide = w;
        @(negedge clk);
        d = reg_rdata;
        reg_re = 1'b0;
    endtask

    // Serve host handshakes until done; mode 1/2 inject writes while busy.
    task automatic run_xfer(input int host, input int len, input int delay, input int mode,
                            output bit seen, output int gap, output int served,
                            output int bad, output logic [31:0] irqv);
        int cyc = 0, last = 0, waitc = 0;
        seen = 0; served = 0; bad = 0; irqv = '0; gap = 0;
        while (!seen && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            reg_we = 1'b0;
            hst_ack = 1'b0;
            if (done) begin
                seen = 1; gap = cyc - last; irqv = irq_set;
            end else if (hst_req) begin
                if (waitc > 0) waitc--;
                else begin
                    hst_ack = 1'b1;
                    if (int'(hst_addr) != host + served) bad++;
                    if (hst_we) hmem[hst_addr] = hst_wdata;
                    else hst_rdata = hmem[hst_addr];
                    served++;
                    last = cyc;
                    waitc = (delay * served) % 3;
                    reg_wide = 1'b1;
                    if (mode == 1 && served == len) begin
                        reg_we = 1'b1; reg_addr = 20'h90; reg_wdata = 64'h33;
                    end
                    if (mode == 2 && served == 1) begin
                        reg_we = 1'b1; reg_addr = 20'h80; reg_wdata = 64'h3AA;
                    end
                    if (mode == 2 && served == 2) begin
                        reg_we = 1'b1; reg_addr = 20'h40000 + 20'd60; reg_wdata = 64'hEE;
                    end
                    if (mode == 2 && served == 3) begin
                        reg_we = 1'b1; reg_addr = 20'h98; reg_wdata = 64'h7;
                    end
                end
            end
        end
        hst_ack = 1'b0;
        reg_we = 1'b0;
    endtask

    task automatic do_xfer(input bit dir, input int host, input int off, input int len,
                           input bit irq, input int delay, input int mode);
        logic [63:0] v;
        bit seen;
        int gap, served, bad;
        logic [31:0] irqv;
        reg_wr(20'h80, dir ? WIN + 64'(off) : 64'(host), 1'b1);
        reg_wr(20'h88, dir ? 64'(host) : WIN + 64'(off), 1'b1);
        reg_wr(20'h90, 64'(len), 1'b1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 20'h98; reg_wide = 1'b1;
        reg_wdata = {61'b0, irq, dir, 1'b1};
        run_xfer(host, len, delay, mode, seen, gap, served, bad, irqv);
        chk("R6 done seen", 64'(seen), 64'd1);
        chk("R6 done one cycle after last byte", 64'(gap), 64'd1);
        chk("R5 handshakes equal count", 64'(served), 64'(len));
        chk(dir ? "R4 host address order" : "R3 host address order", 64'(bad), 64'd0);
        chk("R7 irq at done", 64'(irqv), irq ? 64'h100 : 64'h0);
        if (!dir) begin
            for (int i = 0; i < len; i++) bmodel[off+i] = hmem[host+i];
            for (int j = 0; j < NBUF; j++) begin
                reg_rd(20'h40000 + 20'(j), 1'b0, v);
                chk("R3 buffer byte", v, 64'(bmodel[j]));
            end
        end else begin
            for (int i = 0; i < len; i++) hexp[host+i] = bmodel[off+i];
            for (int i = host - 1; i <= host + len; i++)
                if (i >= 0 && i < HSIZE) chk("R4 host byte", 64'(hmem[i]), 64'(hexp[i]));
        end
        reg_rd(20'h98, 1'b1, v);
        chk("R2 command after copy", v, {61'b0, irq, dir, 1'b0});
    endtask

    task automatic rej(input bit dir, input logic [63:0] s, input logic [63:0] d,
                       input logic [63:0] c);
        logic [63:0] v;
        int rq, dc;
        reg_wr(20'h80, s, 1'b1);
        reg_wr(20'h88, d, 1'b1);
        reg_wr(20'h90, c, 1'b1);
        rq = req_cyc; dc = done_cyc;
        reg_wr(20'h98, {62'b0, dir, 1'b1}, 1'b1);
        repeat (5) @(negedge clk);
        chk("R8 no host request", 64'(req_cyc), 64'(rq));
        chk("R8 no done", 64'(done_cyc), 64'(dc));
        reg_rd(20'h98, 1'b1, v);
        chk("R8 error set, busy clear", v, {60'b0, 1'b1, 1'b0, dir, 1'b0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] v;
        for (int a = 0; a < HSIZE; a++) begin
            hmem[a] = 8'((a * 13 + 5) & 255);
            hexp[a] = hmem[a];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 hst_req", 64'(hst_req), 64'd0);
        chk("R11 done", 64'(done), 64'd0);
        chk("R11 irq_set", 64'(irq_set), 64'd0);
        for (int k = 0; k < 4; k++) begin
            reg_rd(20'h80 + 20'(k * 8), 1'b1, v);
            chk("R11 register zero", v, 64'd0);
        end

        // R1 lanes
        reg_wr(20'h80, 64'h1122334455667788, 1'b1);
        reg_rd(20'h80, 1'b1, v);
        chk("R1 wide readback", v, 64'h1122334455667788);
        reg_wr(20'h84, 64'hFFFF_FFFF_AABBCCDD, 1'b0);
        reg_rd(20'h80, 1'b1, v);
        chk("R1 high lane write", v, 64'hAABBCCDD55667788);
        reg_rd(20'h80, 1'b0, v);
        chk("R1 low lane read", v, 64'h55667788);
        reg_rd(20'h84, 1'b0, v);
        chk("R1 high lane read", v, 64'hAABBCCDD);
        reg_wr(20'h90, 64'h0000_0000_0000_0123, 1'b0);
        reg_rd(20'h90, 1'b1, v);
        chk("R1 count low lane", v, 64'h123);

        // R10 window fill and access
        for (int j = 0; j < NBUF; j++) begin
            bmodel[j] = 8'((j * 29 + 11) & 255);
            reg_wr(20'h40000 + 20'(j), {56'hFFFF_FFFF_FFFF_FF, bmodel[j]}, 1'b0);
        end
        reg_rd(20'h40000 + 20'd5, 1'b0, v);
        chk("R10 window byte", v, 64'(bmodel[5]));
        reg_rd(20'h40000 + 20'd63, 1'b1, v);
        chk("R10 window wide read", v, 64'(bmodel[63]));

        // R3 direction 0 sweep
        do_xfer(1'b0, 16'h010, 0, 1, 1'b1, 0, 0);
        do_xfer(1'b0, 16'h123, 5, 2, 1'b0, 1, 0);
        do_xfer(1'b0, 16'h200, 10, 7, 1'b1, 2, 0);
        do_xfer(1'b0, 16'h3C0, 0, 64, 1'b0, 0, 0);
        do_xfer(1'b0, 16'h055, 63, 1, 1'b1, 1, 0);
        // R4 direction 1 sweep
        do_xfer(1'b1, 16'h300, 0, 64, 1'b1, 1, 0);
        do_xfer(1'b1, 16'h001, 30, 5, 1'b0, 0, 0);
        do_xfer(1'b1, 16'h3FF, 63, 1, 1'b1, 2, 0);
        // R6 zero count
        do_xfer(1'b0, 16'h080, 20, 0, 1'b1, 0, 0);

        // R9 write in the same cycle as the last handshake
        do_xfer(1'b0, 16'h140, 40, 4, 1'b0, 0, 1);
        reg_rd(20'h90, 1'b1, v);
        chk("R9 count write at last byte ignored", v, 64'd4);
        reg_wr(20'h90, 64'd9, 1'b1);
        reg_rd(20'h90, 1'b1, v);
        chk("R9 count write after done applies", v, 64'd9);

        // R9 writes mid-copy (source, window, command)
        do_xfer(1'b0, 16'h250, 0, 8, 1'b0, 1, 2);
        reg_rd(20'h80, 1'b1, v);
        chk("R9 source unchanged", v, 64'h250);

        // R8 refusals
        rej(1'b0, 64'h3F8, WIN, 64'd9);
        rej(1'b0, 64'h010, WIN + 64'd60, 64'd5);
        rej(1'b0, 64'h010, 64'h3FFFF, 64'd1);
        rej(1'b1, WIN, 64'h100, 64'd65);
        // R8 accepted start clears error (checked via command read)
        do_xfer(1'b0, 16'h0F0, 32, 3, 1'b0, 0, 0);

        chk("R7 no irq outside done", 64'(irq_stray), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule